// File: doc/BRIEF.md
# Clock Output Channel with Source Select and Table Divider

This block forms one clock output channel. It picks one of four incoming clocks: the reference clock or one of three PLL clocks. It then divides the chosen clock by a ratio taken from a fixed sixteen-entry table that runs from 1 to 50 with gaps. The channel drives the divided clock together with a separate drive-enable flag for an external tristate pad.

Two register banks each hold a source code and a divide code. A bank-select pin decides which bank is live, so a board signal can move the channel between two prepared settings without any register write. A power-down pin, gated by a per-channel enable bit, parks the output low. The output-enable input controls only the drive-enable flag.

A change of source or ratio while the channel runs may give one short or long pulse. That is accepted. The divider never runs away, however: a count that is past the new terminal wraps on the next edge.

Top module: `clkout_channel`

## Requirements
- R1: Source code 2'b00 selects the reference clock, 2'b01 PLL A, 2'b10 PLL B and 2'b11 PLL C.
- R2: Divide codes 0 to 15 give the ratios 1, 2, 3, 4, 5, 6, 8, 9, 10, 12, 15, 16, 18, 20, 25 and 50, in that order. The output period is the ratio times the selected source period.
- R3: For a ratio N above 1, the output is high for floor(N/2) source periods and low for the rest, so even ratios give a 50% duty cycle.
- R4: Ratio 1 passes the selected source clock straight to the output, with its own duty cycle.
- R5: With bank_sel low, the bank-1 source and divide codes are used and the bank-2 codes have no effect. With bank_sel high, the reverse holds.
- R6: While rst_n is low, the divided output stays low for any ratio above 1. With all codes zero, the output equals the reference clock, even during reset.
- R7: When pd_pin and pd_en are both high, clk_out is held low. Either input high on its own has no effect on the output.
- R8: clk_oe follows oe. A low oe does not stop the clock on clk_out.
- R9: After any code change, the divide counter is below the new ratio from the next source edge onward. The first output rising edge on the new setting comes within four source periods for ratio 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock, source code 0 |
| clk_pll_a | input | 1 | PLL A clock, source code 1 |
| clk_pll_b | input | 1 | PLL B clock, source code 2 |
| clk_pll_c | input | 1 | PLL C clock, source code 3 |
| rst_n | input | 1 | Active-low reset, synchronous to the selected source clock |
| bank_sel | input | 1 | 0 selects bank-1 codes, 1 selects bank-2 codes |
| src_code_b1 | input | 2 | Bank-1 source code |
| div_code_b1 | input | 4 | Bank-1 divide code |
| src_code_b2 | input | 2 | Bank-2 source code |
| div_code_b2 | input | 4 | Bank-2 divide code |
| pd_pin | input | 1 | Power-down request pin |
| pd_en | input | 1 | Channel power-down enable bit |
| oe | input | 1 | Output enable |
| clk_out | output | 1 | Divided (or bypassed) clock |
| clk_oe | output | 1 | Drive enable for the output pad |

## Verification
On every edge of the selected source clock, the assertions check four things:
- the one-hot source decode;
- the counter bound and wrap after a code change;
- rising edges of the divided output occurring only at a counter wrap;
- the forced-low output under power-down and the drive-enable flag.

The exact periods and high times for each table entry, the bank swap and the bypass at ratio 1 cannot be seen from one edge to the next. Only the bench's timed measurements of clk_out show them.

// File: rtl/ckch_pkg.sv
// Package for the clock output channel: sizes and the divide-ratio lookup.
// Assumes a 4-bit divide code; ratios fit in 6 bits.
package ckch_pkg;
    localparam int NUM_SRC = 4;
    localparam int SRC_W   = $clog2(NUM_SRC);
    localparam int CODE_W  = 4;
    localparam int CNT_W   = 6;

    // Maps a divide code to its non-linear ratio (R2).
    function automatic logic [CNT_W-1:0] ratio_of(input logic [CODE_W-1:0] code);
        logic [CNT_W-1:0] r;
        case (code)
            4'd0:    r = 6'd1;
            4'd1:    r = 6'd2;
            4'd2:    r = 6'd3;
            4'd3:    r = 6'd4;
            4'd4:    r = 6'd5;
            4'd5:    r = 6'd6;
            4'd6:    r = 6'd8;
            4'd7:    r = 6'd9;
            4'd8:    r = 6'd10;
            4'd9:    r = 6'd12;
            4'd10:   r = 6'd15;
            4'd11:   r = 6'd16;
            4'd12:   r = 6'd18;
            4'd13:   r = 6'd20;
            4'd14:   r = 6'd25;
            default: r = 6'd50;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/ckch_bank_pick.sv
// Chooses the live source and divide codes from one of two banks.
// Assumes bank_sel is a level; switching it live is allowed to glitch.
module ckch_bank_pick #(
    parameter int SRC_W  = 2,
    parameter int CODE_W = 4
) (
    input  logic              bank_sel,
    input  logic [SRC_W-1:0]  src_b1,
    input  logic [CODE_W-1:0] div_b1,
    input  logic [SRC_W-1:0]  src_b2,
    input  logic [CODE_W-1:0] div_b2,
    output logic [SRC_W-1:0]  src_live,
    output logic [CODE_W-1:0] div_live
);
    // Bank choice for both codes together (R5).
    always_comb begin
        src_live = bank_sel ? src_b2 : src_b1;
        div_live = bank_sel ? div_b2 : div_b1;
    end
endmodule

// File: rtl/ckch_src_mux.sv
// AND-OR clock selector driven by a one-hot decode of the source code.
// Assumes no glitch protection is required when the code changes.
module ckch_src_mux #(
    parameter int NUM_SRC = 4,
    parameter int SEL_W   = 2
) (
    input  logic [NUM_SRC-1:0] clk_in,
    input  logic [SEL_W-1:0]   sel,
    output logic               clk_sel
);
    logic [NUM_SRC-1:0] sel_oh;
    logic [NUM_SRC-1:0] gated;

    // One decode bit and one gated clock per source (R1).
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign sel_oh[i] = (sel == SEL_W'(i));
        assign gated[i]  = clk_in[i] & sel_oh[i];
    end

    // Merge of the gated clocks.
    assign clk_sel = |gated;

    // R1: exactly one source is enabled for any defined code.
    always_comb begin
        a_r1_onehot_pick: assert ($isunknown(sel) || $onehot(sel_oh));
    end
endmodule

// File: rtl/ckch_post_div.sv
// Post divider clocked by the selected source. A ratio of 1 bypasses the
// counter; other ratios give a registered output high for floor(N/2) cycles.
// Assumes the reset is synchronous to clk_src; hold parks the counter.
module ckch_post_div
    import ckch_pkg::*;
(
    input  logic              clk_src,
    input  logic              rst_n,
    input  logic              hold,
    input  logic [CODE_W-1:0] code,
    output logic              div_out
);
    logic [CNT_W-1:0] ratio;
    logic [CNT_W-1:0] half;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nx;
    logic             div_q;

    // Lookup of the ratio and its high phase length (R2, R3).
    always_comb begin
        ratio  = ratio_of(code);
        half   = ratio >> 1;
        cnt_nx = (cnt >= ratio - CNT_W'(1)) ? '0 : cnt + CNT_W'(1);
    end

    // Counter and registered output phase (R3, R9).
    always_ff @(posedge clk_src) begin
        if (!rst_n || hold) begin
            cnt   <= '0;
            div_q <= 1'b0;
        end else begin
            cnt   <= cnt_nx;
            div_q <= (cnt_nx < half);
        end
    end

    // Bypass for ratio 1, divided phase otherwise (R4).
    assign div_out = (ratio == CNT_W'(1)) ? clk_src : div_q;

    // R9: with the code steady, the counter stays below the ratio.
    a_r9_cnt_bound: assert property (@(posedge clk_src) disable iff (!rst_n)
        ($stable(code) && !hold) |-> (cnt < ratio));

    // R9: a count at or past the terminal wraps on the next edge.
    a_r9_wrap: assert property (@(posedge clk_src) disable iff (!rst_n)
        (!hold && cnt >= ratio - CNT_W'(1)) |=> (cnt == '0));

    // R3: the divided phase rises only when the counter wraps.
    a_r3_rise_at_wrap: assert property (@(posedge clk_src) disable iff (!rst_n)
        ($rose(div_q) && $stable(code) && $past(cnt) != '0) |-> (cnt == '0));

    // R7: a held divider is parked low with a cleared count.
    a_r7_hold_parks: assert property (@(posedge clk_src) disable iff (!rst_n)
        hold |=> (cnt == '0 && !div_q));
endmodule

// File: rtl/clkout_channel.sv
// One clock output channel: bank choice, source selection, table divider,
// power-down forcing and pad drive enable.
// Assumes rst_n is synchronous to whichever source is selected.
module clkout_channel
    import ckch_pkg::*;
(
    input  logic              clk_ref,
    input  logic              clk_pll_a,
    input  logic              clk_pll_b,
    input  logic              clk_pll_c,
    input  logic              rst_n,
    input  logic              bank_sel,
    input  logic [SRC_W-1:0]  src_code_b1,
    input  logic [CODE_W-1:0] div_code_b1,
    input  logic [SRC_W-1:0]  src_code_b2,
    input  logic [CODE_W-1:0] div_code_b2,
    input  logic              pd_pin,
    input  logic              pd_en,
    input  logic              oe,
    output logic              clk_out,
    output logic              clk_oe
);
    logic [SRC_W-1:0]  src_live;
    logic [CODE_W-1:0] div_live;
    logic              sel_clk;
    logic              div_clk;
    logic              pd_act;

    ckch_bank_pick #(.SRC_W(SRC_W), .CODE_W(CODE_W)) u_bank (
        .bank_sel (bank_sel),
        .src_b1   (src_code_b1),
        .div_b1   (div_code_b1),
        .src_b2   (src_code_b2),
        .div_b2   (div_code_b2),
        .src_live (src_live),
        .div_live (div_live)
    );

    ckch_src_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SRC_W)) u_mux (
        .clk_in  ({clk_pll_c, clk_pll_b, clk_pll_a, clk_ref}),
        .sel     (src_live),
        .clk_sel (sel_clk)
    );

    // Power-down is active only when the pin and the enable bit agree (R7).
    assign pd_act = pd_pin & pd_en;

    ckch_post_div u_div (
        .clk_src (sel_clk),
        .rst_n   (rst_n),
        .hold    (pd_act),
        .code    (div_live),
        .div_out (div_clk)
    );

    // Output forcing and drive enable (R7, R8).
    always_comb begin
        clk_out = pd_act ? 1'b0 : div_clk;
        clk_oe  = oe;
    end

    // R7: power-down keeps the pin low at every source edge.
    a_r7_forced_low: assert property (@(posedge sel_clk) disable iff (!rst_n)
        (pd_pin && pd_en) |-> !clk_out);

    // R8: the drive enable is off whenever oe is low.
    a_r8_drive_off: assert property (@(posedge sel_clk) disable iff (!rst_n)
        !oe |-> !clk_oe);
endmodule

// File: tb/clkout_channel_test.sv
`timescale 1ns/1ps
// Bench for clkout_channel: a vector table walked by one loop, then directed
// tests for reset, bypass, power-down, output enable and live code changes.
module clkout_channel_test;
    logic       clk = 1'b0;
    logic       pa = 1'b0, pb = 1'b0, pc = 1'b0;
    logic       rst_n = 1'b0;
    logic       bank_sel = 1'b0;
    logic [1:0] m1 = 2'd0, m2 = 2'd0;
    logic [3:0] d1 = 4'd0, d2 = 4'd0;
    logic       pd_pin = 1'b0, pd_en = 1'b0, oe = 1'b1;
    logic       clk_out, clk_oe;
    int         n_checks = 0;
    int         n_err = 0;

    always #2 clk = ~clk;   // 250 MHz reference, 4 ns period
    always #3 pa  = ~pa;    // PLL A, 6 ns
    always #5 pb  = ~pb;    // PLL B, 10 ns
    always #7 pc  = ~pc;    // PLL C, 14 ns

    clkout_channel uut (
        .clk_ref(clk), .clk_pll_a(pa), .clk_pll_b(pb), .clk_pll_c(pc),
        .rst_n(rst_n), .bank_sel(bank_sel),
        .src_code_b1(m1), .div_code_b1(d1), .src_code_b2(m2), .div_code_b2(d2),
        .pd_pin(pd_pin), .pd_en(pd_en), .oe(oe),
        .clk_out(clk_out), .clk_oe(clk_oe)
    );

    typedef struct packed {
        logic        bank;
        logic [1:0]  s1;
        logic [3:0]  c1;
        logic [1:0]  s2;
        logic [3:0]  c2;
        int unsigned per;
        int unsigned ratio;
    } vec_t;

    // bank, bank-1 codes, bank-2 codes, expected source period, expected ratio
    localparam vec_t VECS [16] = '{
        '{1'b0, 2'd0, 4'd0,  2'd0, 4'd0,  4,  1},
        '{1'b0, 2'd1, 4'd1,  2'd0, 4'd0,  6,  2},
        '{1'b0, 2'd2, 4'd2,  2'd0, 4'd0,  10, 3},
        '{1'b0, 2'd3, 4'd6,  2'd0, 4'd0,  14, 8},
        '{1'b1, 2'd0, 4'd0,  2'd1, 4'd15, 6,  50},
        '{1'b1, 2'd0, 4'd0,  2'd0, 4'd10, 4,  15},
        '{1'b1, 2'd0, 4'd0,  2'd3, 4'd7,  14, 9},
        '{1'b0, 2'd2, 4'd14, 2'd3, 4'd0,  10, 25},
        '{1'b1, 2'd0, 4'd0,  2'd2, 4'd12, 10, 18},
        '{1'b0, 2'd0, 4'd3,  2'd0, 4'd0,  4,  4},
        '{1'b0, 2'd0, 4'd4,  2'd0, 4'd0,  4,  5},
        '{1'b0, 2'd0, 4'd5,  2'd0, 4'd0,  4,  6},
        '{1'b0, 2'd0, 4'd8,  2'd0, 4'd0,  4,  10},
        '{1'b0, 2'd1, 4'd9,  2'd0, 4'd0,  6,  12},
        '{1'b1, 2'd3, 4'd13, 2'd0, 4'd11, 4,  16},
        '{1'b1, 2'd1, 4'd2,  2'd0, 4'd13, 4,  20}
    };

    task automatic check_eq(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Skips two output periods to settle, then times one period and its high phase.
    task automatic measure(output longint per, output longint hi);
        time t0, t1, t2;
        @(posedge clk_out);
        @(posedge clk_out);
        t0 = $time;
        @(negedge clk_out);
        t1 = $time;
        @(posedge clk_out);
        t2 = $time;
        per = longint'(t2 - t0);
        hi  = longint'(t1 - t0);
    endtask

    // Counts samples of clk_out that are high over a window, off the edges.
    task automatic count_high(input int samples, output int highs);
        highs = 0;
        #0.5;
        for (int i = 0; i < samples; i++) begin
            if (clk_out) highs++;
            #1;
        end
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        n_checks++;
        $display("FAIL R3 watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        longint per, hi;
        int     highs;
        time    tc;

        // R6: in reset with all codes zero, the output follows the reference.
        repeat (3) @(posedge clk);
        #1;
        check_eq("R6 ref high in reset", clk_out, 1);
        check_eq("R8 drive enable at reset", clk_oe, 1);
        @(negedge clk);
        #1;
        check_eq("R6 ref low in reset", clk_out, 0);

        // R6: a ratio above 1 keeps the output low while in reset.
        @(negedge clk);
        d1 = 4'd1;
        repeat (3) @(negedge clk);
        count_high(40, highs);
        check_eq("R6 divided output low in reset", highs, 0);
        @(negedge clk);
        rst_n = 1'b1;
        measure(per, hi);
        check_eq("R6 first ratio-2 period after reset", per, 8);
        check_eq("R3 first ratio-2 high after reset", hi, 4);

        // R1, R2, R3, R4, R5: table walk.
        foreach (VECS[k]) begin
            @(negedge clk);
            bank_sel = VECS[k].bank;
            m1 = VECS[k].s1; d1 = VECS[k].c1;
            m2 = VECS[k].s2; d2 = VECS[k].c2;
            measure(per, hi);
            check_eq($sformatf("R1/R2/R5 period vec %0d", k), per,
                     longint'(VECS[k].per * VECS[k].ratio));
            if (VECS[k].ratio == 1)
                check_eq($sformatf("R4 bypass high vec %0d", k), hi,
                         longint'(VECS[k].per / 2));
            else
                check_eq($sformatf("R3 high time vec %0d", k), hi,
                         longint'((VECS[k].ratio / 2) * VECS[k].per));
        end

        // R4: bypass on PLL B at ratio 1.
        @(negedge clk);
        bank_sel = 1'b0; m1 = 2'd2; d1 = 4'd0;
        measure(per, hi);
        check_eq("R4 bypass PLL B period", per, 10);
        check_eq("R4 bypass PLL B high", hi, 5);

        // R7: power-down with both inputs high forces low, bypass and divided.
        @(negedge clk);
        pd_pin = 1'b1; pd_en = 1'b1;
        count_high(60, highs);
        check_eq("R7 forced low on bypass", highs, 0);
        @(negedge clk);
        m1 = 2'd1; d1 = 4'd1;
        count_high(60, highs);
        check_eq("R7 forced low on divided", highs, 0);

        // R7: pin alone and enable alone have no effect.
        @(negedge clk);
        pd_en = 1'b0;
        measure(per, hi);
        check_eq("R7 pin alone period", per, 12);
        @(negedge clk);
        pd_pin = 1'b0; pd_en = 1'b1;
        measure(per, hi);
        check_eq("R7 enable alone period", per, 12);
        pd_en = 1'b0;

        // R8: oe low drops the drive enable but the clock keeps running.
        @(negedge clk);
        oe = 1'b0;
        #1;
        check_eq("R8 drive enable off", clk_oe, 0);
        measure(per, hi);
        check_eq("R8 clock runs with oe low", per, 12);
        @(negedge clk);
        oe = 1'b1;
        #1;
        check_eq("R8 drive enable on", clk_oe, 1);

        // R9: a live switch from ratio 50 to ratio 2 recovers within a few edges.
        @(negedge clk);
        m1 = 2'd1; d1 = 4'd15;
        @(posedge clk_out);
        @(posedge clk_out);
        #20;
        @(negedge clk);
        m1 = 2'd0; d1 = 4'd1;
        tc = $time;
        @(posedge clk_out);
        check_eq("R9 first rise within 16 ns", ($time - tc) <= 16 ? 1 : 0, 1);
        measure(per, hi);
        check_eq("R9 period after live change", per, 8);

        // R5: the inactive bank has no effect on the output.
        @(negedge clk);
        bank_sel = 1'b0; m1 = 2'd0; d1 = 4'd3;
        m2 = 2'd3; d2 = 4'd15;
        measure(per, hi);
        check_eq("R5 bank-2 ignored period", per, 16);

        summary();
        $finish;
    end
endmodule